// File: doc/BRIEF.md
# Shared Memory Target Cycle Controller

This block is the target side of a shared memory sitting on a local bus with a separate address strobe. A master starts an access by raising the address strobe together with an address, a write/read select and a two-bit burst length. The controller then runs one or more data transfers. Before each transfer it waits out a fixed number of wait states. It signals every completed transfer with a ready strobe, and it marks the final transfer of the access with a burst-last strobe.

The storage is a small synchronous word array inside the block. Writes land in it on the ready clock. Read data for the current address is presented for as long as ready is high. A slow master that issues a single-word read can keep the word and the ready strobe on the bus by holding an extend input. The access ends on the first clock where extend has been released. The wait-state count is a design parameter from 0 to 7, and a burst carries one to four words.

Top module: `smc_target`

## Requirements
- R1: While reset is asserted, and in every cycle with no access in progress, rdy and blast are both low. Reset returns the controller to idle, including from the middle of an access.
- R2: Each transfer has exactly WAIT_ST cycles with rdy low. These are counted from the clock that accepted ads, or from the clock that completed the previous transfer. They are followed by one cycle with rdy high (WAIT_ST = 0 gives rdy in the first data cycle).
- R3: The blen field is sampled with ads, and a value n gives n+1 transfers. The two low address bits step by +1 after each transfer and wrap modulo 4. The upper address bits stay fixed.
- R4: blast is high exactly in the rdy cycle or cycles of the last transfer and never without rdy. It is low again in the cycle after the clock that ends the access.
- R5: On a write, wdata is stored at the current word address on the clock edge at which rdy is high.
- R6: On a read, rdata equals the stored word at the current address in every cycle in which rdy is high.
- R7: On a single-transfer read (blen = 0, wr = 0), each clock where rdy and blast are high with extend high keeps the access open. rdy, blast and rdata then stay unchanged in the next cycle. The first such clock with extend low ends the access.
- R8: extend has no effect on writes or on bursts (blen ≠ 0). Their rdy and blast timing and their ending are those of R2 and R4.
- R9: An ads pulse that arrives while an access is in progress is ignored, including in its final ready cycle. A new access is accepted only from the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ads | input | 1 | Address strobe, starts an access when idle |
| wr | input | 1 | 1 = write access, 0 = read access, sampled with ads |
| addr | input | AW | Word address of the first transfer, sampled with ads |
| blen | input | 2 | Number of transfers minus one, sampled with ads |
| extend | input | 1 | Stretch request for single-transfer reads |
| wdata | input | DW | Write data, taken on the rdy clock |
| rdata | output | DW | Read data for the current address |
| rdy | output | 1 | Transfer ready strobe |
| blast | output | 1 | Last transfer of the access |

## Verification
The accepting clock edge loads the wait counter, so the first rdy comes WAIT_ST cycles after that edge, and each later beat comes WAIT_ST+1 cycles after the previous rdy. blast appears in the same cycle as the last rdy, and both outputs are low one cycle after the ending edge. A written word shows up on rdata in a later read access, and under extend the read word is held for as many extra cycles as extend stays high. The bench drives all inputs and samples all outputs on the falling edge. It walks through the access cycle by cycle, comparing against counts it derives from WAIT_ST, blen and the extend length, so each output is sampled in exactly the cycle it is due.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } smc_state_e;
endpackage

// File: rtl/smc_wait_ctr.sv
module smc_wait_ctr #(
  parameter int CW      = 3,
  parameter int WAIT_ST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic zero
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = cnt_q;
    if (load)     cnt_d = CW'(WAIT_ST);
    else if (dec) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/smc_burst_seq.sv
module smc_burst_seq
  import smc_pkg::*;
#(
  parameter int AW = 4,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ads,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] blen,
  input  logic          extend,
  input  logic          cnt_zero,
  output logic          cnt_load,
  output logic          cnt_dec,
  output logic          rdy,
  output logic          blast,
  output logic          mem_we,
  output logic [AW-1:0] cur_addr,
  output logic          busy,
  output logic          stretch_ok
);
  smc_state_e    state_q, state_d;
  logic [LW-1:0] beat_q, beat_d, len_q, len_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          wr_q, wr_d, ok_q, ok_d;
  logic          accept, xfer, last, hold, adv, seq_en;

  always_comb begin
    accept = (state_q == ST_IDLE) & ads;
    xfer   = (state_q == ST_DATA) & cnt_zero;
    last   = (beat_q == len_q);
    hold   = xfer & last & ok_q & extend;
    adv    = xfer & ~hold;
    seq_en = accept | adv;

    state_d = state_q;
    beat_d  = beat_q;
    len_d   = len_q;
    addr_d  = addr_q;
    wr_d    = wr_q;
    ok_d    = ok_q;
    if (accept) begin
      state_d = ST_DATA;
      beat_d  = '0;
      len_d   = blen;
      addr_d  = addr;
      wr_d    = wr;
      ok_d    = ~wr & (blen == '0);
    end else if (adv) begin
      if (last) begin
        state_d = ST_IDLE;
      end else begin
        beat_d = beat_q + LW'(1);
        addr_d = {addr_q[AW-1:LW], addr_q[LW-1:0] + LW'(1)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      ok_q    <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      beat_q  <= beat_d;
      len_q   <= len_d;
      addr_q  <= addr_d;
      wr_q    <= wr_d;
      ok_q    <= ok_d;
    end
  end

  assign cnt_load   = accept | (adv & ~last);
  assign cnt_dec    = (state_q == ST_DATA) & ~cnt_zero;
  assign rdy        = xfer;
  assign blast      = xfer & last;
  assign mem_we     = xfer & wr_q;
  assign cur_addr   = addr_q;
  assign busy       = (state_q == ST_DATA);
  assign stretch_ok = ok_q;
endmodule

// File: rtl/smc_mem.sv
module smc_mem #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words_q[addr] <= wdata;
  end

  assign rdata = words_q[addr];
endmodule

// File: rtl/smc_target.sv
module smc_target #(
  parameter int AW        = 4,
  parameter int DW        = 16,
  parameter int WAIT_ST   = 2,
  parameter int MAX_WAIT  = 7,
  parameter int BURST_MAX = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ads,
  input  logic                         wr,
  input  logic [AW-1:0]                addr,
  input  logic [$clog2(BURST_MAX)-1:0] blen,
  input  logic                         extend,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output logic                         rdy,
  output logic                         blast
);
  localparam int CW = $clog2(MAX_WAIT + 1);
  localparam int LW = $clog2(BURST_MAX);

  logic          cnt_zero, cnt_load, cnt_dec, mem_we;
  logic          busy, stretch_ok;
  logic [AW-1:0] cur_addr;

  smc_wait_ctr #(.CW(CW), .WAIT_ST(WAIT_ST)) u_wait (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cnt_load),
    .dec  (cnt_dec),
    .zero (cnt_zero)
  );

  smc_burst_seq #(.AW(AW), .LW(LW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads       (ads),
    .wr        (wr),
    .addr      (addr),
    .blen      (blen),
    .extend    (extend),
    .cnt_zero  (cnt_zero),
    .cnt_load  (cnt_load),
    .cnt_dec   (cnt_dec),
    .rdy       (rdy),
    .blast     (blast),
    .mem_we    (mem_we),
    .cur_addr  (cur_addr),
    .busy      (busy),
    .stretch_ok(stretch_ok)
  );

  smc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .addr (cur_addr),
    .wdata(wdata),
    .rdata(rdata)
  );
endmodule

// File: rtl/smc_target_chk.sv
module smc_target_chk #(
  parameter int WAIT_ST = 2,
  parameter int CW      = 3,
  parameter int DW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rdy,
  input logic          blast,
  input logic          extend,
  input logic          busy,
  input logic          stretch_ok,
  input logic [DW-1:0] rdata
);
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap_q <= '0;
    else if (!busy || rdy) gap_q <= '0;
    else                   gap_q <= gap_q + CW'(1);
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rdy && !blast)); // R1

  AST_WAIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> (gap_q == CW'(WAIT_ST))); // R2

  AST_BLAST_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    blast |-> rdy); // R4

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && blast && extend && stretch_ok) |=> (rdy && blast && $stable(rdata))); // R7

  AST_END_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && blast && !(extend && stretch_ok)) |=> !busy); // R8

  AST_BUSY_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !blast) |=> busy); // R9
endmodule

bind smc_target smc_target_chk #(.WAIT_ST(WAIT_ST), .CW(CW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdy       (rdy),
  .blast     (blast),
  .extend    (extend),
  .busy      (busy),
  .stretch_ok(stretch_ok),
  .rdata     (rdata)
);

// File: tb/sim_smc_target.sv
module sim_smc_target;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int WAIT_ST = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ads = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    blen = '0;
  logic          extend = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdy, blast;

  logic [DW-1:0] model [16];
  int vectors = 0;
  int errors  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smc_target #(.AW(AW), .DW(DW), .WAIT_ST(WAIT_ST)) u0 (
    .clk(clk), .rst_n(rst_n), .ads(ads), .wr(wr), .addr(addr), .blen(blen),
    .extend(extend), .wdata(wdata), .rdata(rdata), .rdy(rdy), .blast(blast)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return {a[AW-1:2], a[1:0] + 2'd1};
  endfunction

  function automatic bit can_stretch(input bit w, input logic [1:0] n);
    return !w && (n == 2'd0);
  endfunction

  // One access from the idle state; all driving and sampling on falling edges.
  task automatic access(input logic [AW-1:0] a, input bit w, input logic [1:0] n,
                        input bit ext, input int ext_cycles, input bit ads_busy);
    logic [AW-1:0] cur;
    logic [DW-1:0] v;
    bit last;
    @(negedge clk);
    ads = 1'b1; addr = a; wr = w; blen = n; extend = 1'b0;
    @(negedge clk);
    ads = ads_busy;
    if (ads_busy) begin addr = ~a; wr = ~w; blen = ~n; end
    extend = ext;
    cur = a;
    for (int b = 0; b <= int'(n); b++) begin
      last = (b == int'(n));
      for (int i = 0; i < WAIT_ST; i++) begin
        chk(!rdy && !blast, "R2 wait cycle rdy/blast low", {rdy, blast}, 0);
        @(negedge clk);
      end
      chk(rdy, "R2 rdy after wait states", rdy, 1);
      chk(blast == last, "R4 blast only on last transfer", blast, last);
      if (!w) chk(rdata == model[cur], "R6 R3 read data at address", rdata, model[cur]);
      else begin
        v = DW'($urandom);
        wdata = v;
        model[cur] = v;
      end
      if (last) ads = 1'b0;
      if (last && can_stretch(w, n) && ext) begin
        if (ext_cycles == 0) extend = 1'b0;
        for (int h = 0; h < ext_cycles; h++) begin
          @(negedge clk);
          chk(rdy && blast, "R7 extend holds rdy and blast", {rdy, blast}, 3);
          chk(rdata == model[cur], "R7 extend holds read data", rdata, model[cur]);
          if (h == ext_cycles - 1) extend = 1'b0;
        end
      end
      @(negedge clk);
      cur = next_addr(cur);
    end
    chk(!rdy && !blast, "R4 R8 R9 idle after access end", {rdy, blast}, 0);
    extend = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(!rdy && !blast, "R1 outputs low in reset", {rdy, blast}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rdy && !blast, "R1 idle after reset", {rdy, blast}, 0);

    // R5: fill every word with single writes
    for (int k = 0; k < 16; k++) access(AW'(k), 1'b1, 2'd0, 1'b0, 0, 1'b0);
    // R3: burst read wrapping inside a 4-word group
    access(4'hE, 1'b0, 2'd3, 1'b0, 0, 1'b0);
    // R5 R3: burst write, then read back
    access(4'h5, 1'b1, 2'd2, 1'b0, 0, 1'b0);
    access(4'h4, 1'b0, 2'd3, 1'b0, 0, 1'b0);
    // R7: stretched single read
    access(4'h9, 1'b0, 2'd0, 1'b1, 3, 1'b0);
    access(4'h2, 1'b0, 2'd0, 1'b1, 0, 1'b0);
    // R8: extend on a write and on a burst read
    access(4'h7, 1'b1, 2'd0, 1'b1, 0, 1'b0);
    access(4'hA, 1'b0, 2'd1, 1'b1, 0, 1'b0);
    access(4'h7, 1'b0, 2'd0, 1'b0, 0, 1'b0);
    // R9: address strobe held during access
    access(4'h3, 1'b1, 2'd1, 1'b0, 0, 1'b1);
    access(4'h0, 1'b0, 2'd3, 1'b0, 0, 1'b0);

    // R1: reset in the middle of an access
    @(negedge clk);
    ads = 1'b1; addr = 4'h8; wr = 1'b0; blen = 2'd3;
    @(negedge clk);
    ads = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!rdy && !blast, "R1 async reset mid access", {rdy, blast}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rdy && !blast, "R1 idle after mid access reset", {rdy, blast}, 0);
    access(4'h8, 1'b0, 2'd1, 1'b0, 0, 1'b0);

    for (int t = 0; t < 80; t++) begin
      access(AW'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
             int'($urandom % 4), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule